// File: doc/BRIEF.md
# Strided MMIO to ATA Task-File Bridge

This block is a bus slave that owns a 4 KiB address window and turns host byte, halfword and word accesses into single-cycle strobes toward an ATA task-file model. The register index is address bits [11:4], so the registers sit 16 bytes apart. The bridge ignores address bits below bit 4 and above bit 11.

Byte accesses reach the seven command-block registers and the device-control / alternate-status register. That register answers at two aliased indices. Halfword and word accesses reach only the data port. Their bytes are reversed in both directions, so a big-endian host sees the little-endian data stream in its natural order. Reads that hit no register return all ones and never touch the drive. Writes that hit no register are acknowledged and dropped.

A two-state controller runs the host handshake. In `ST_IDLE`, writes and unmapped reads finish in the request cycle. A mapped read takes the *issue* transition to `ST_WAIT`, which gives one wait state while the drive returns its data. The *complete* transition always leads from `ST_WAIT` back to `ST_IDLE`.

Top module: `ata_mmio_bridge`

## Requirements
- R1: The register index is host_addr[11:4]. Address bits [3:0] and any bits above bit 11 do not change the decode.
- R2: A byte access (host_size 0) at index 1 to 7 produces a strobe with dev_sel equal to that index.
- R3: A byte access at index 8 or 22 produces a strobe with dev_sel 8. A write there is a device-control write, and a read there is an alternate-status read. Only a byte read at index 7 produces a read strobe with dev_sel 7, which is the status read that lets the drive clear its interrupt. An alternate-status read never does.
- R4: A byte access at any other index produces no strobe. A read there returns 0x000000FF.
- R5: Halfword (host_size 1) and word (host_size 2) accesses act only at index 0, with dev_sel 0. At other indices they produce no strobe, and reads return 0x0000FFFF and 0xFFFFFFFF respectively. host_size 3 is never mapped, and a read with it returns 0xFFFFFFFF.
- R6: Halfword data are byte-swapped in the low 16 bits and word data are fully byte-reversed, on writes (host_wdata to dev_wdata) and on reads (dev_rdata to host_rdata). Byte data travel in bits [7:0] and the upper bits are zero.
- R7: A mapped read pulses dev_rd for exactly the request cycle and raises host_ack in the next cycle. That cycle's host_rdata is formed from dev_rdata in that same cycle.
- R8: Writes and unmapped reads raise host_ack in the request cycle. dev_wr pulses only in that cycle, and never together with dev_rd.
- R9: After reset the controller is in ST_IDLE. With host_req low, host_ack, dev_rd and dev_wr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| host_addr | input | ADDR_W | Byte address inside the window |
| host_wdata | input | DATA_W | Write data, host byte order |
| host_ack | output | 1 | Access complete |
| host_rdata | output | DATA_W | Read data, valid with host_ack |
| dev_sel | output | 4 | Target register: 0 data, 1-7 command block, 8 control/alt status |
| dev_size | output | 2 | Access width toward the drive |
| dev_rd | output | 1 | Read strobe |
| dev_wr | output | 1 | Write strobe |
| dev_wdata | output | DATA_W | Write data, drive byte order |
| dev_rdata | input | DATA_W | Read data, returned the cycle after dev_rd |

## Verification
The assertions assume the host keeps host_req and its qualifiers stable until host_ack, and drops the request in the cycle after host_ack. They also assume the drive presents read data one cycle after dev_rd. The bench drives every access from a single task that holds the request through the acknowledge and releases it one cycle later. Its drive model registers dev_rdata on the edge that samples dev_rd, so both assumptions hold for every vector.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } bridge_state_e;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_DATA = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL = 4'd8;

endpackage

// File: rtl/ata_idx_decode.sv
module ata_idx_decode
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_LO    = 4,
    parameter int IDX_HI    = 11,
    parameter int TF_FIRST  = 1,
    parameter int TF_LAST   = 7,
    parameter int CTL_IDX_A = 8,
    parameter int CTL_IDX_B = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              hit,
    output logic [SEL_W-1:0]  sel
);
    localparam int IDX_W = IDX_HI - IDX_LO + 1;

    logic [IDX_W-1:0] idx;
    logic             in_block;
    logic             is_ctrl;

    assign idx      = addr[IDX_HI:IDX_LO];
    assign in_block = (idx >= IDX_W'(TF_FIRST)) && (idx <= IDX_W'(TF_LAST));
    assign is_ctrl  = (idx == IDX_W'(CTL_IDX_A)) || (idx == IDX_W'(CTL_IDX_B));

    always_comb begin
        hit = 1'b0;
        sel = SEL_DATA;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                if (in_block) begin
                    hit = 1'b1;
                    sel = idx[SEL_W-1:0];
                end else if (is_ctrl) begin
                    hit = 1'b1;
                    sel = SEL_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                hit = (idx == '0);
            end
            SZ_RSVD: begin
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ata_lane_swap.sv
module ata_lane_swap
    import ata_bridge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES     = DATA_W / 8;
    localparam int HALF_LNS  = 2;

    logic [DATA_W-1:0]     full_rev;
    logic [8*HALF_LNS-1:0] half_rev;

    for (genvar i = 0; i < LANES; i++) begin : g_full
        assign full_rev[8*i +: 8] = din[8*(LANES-1-i) +: 8];
    end

    for (genvar j = 0; j < HALF_LNS; j++) begin : g_half
        assign half_rev[8*j +: 8] = din[8*(HALF_LNS-1-j) +: 8];
    end

    always_comb begin
        dout = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: dout[7:0]            = din[7:0];
            SZ_HALF: dout[8*HALF_LNS-1:0] = half_rev;
            SZ_WORD: dout                 = full_rev;
            SZ_RSVD: dout                 = '0;
        endcase
    end
endmodule

// File: rtl/ata_mmio_bridge.sv
module ata_mmio_bridge
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [1:0]        host_size,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [3:0]        dev_sel,
    output logic [1:0]        dev_size,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);
    localparam int HALF_W = 16;

    bridge_state_e    state_q, state_d;
    logic [1:0]       size_q;
    logic [SEL_W-1:0] sel_q;
    logic             dec_hit;
    logic [SEL_W-1:0] dec_sel;
    logic [DATA_W-1:0] rd_swapped;
    logic [DATA_W-1:0] miss_data;
    logic             issue_rd;

    ata_idx_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr (host_addr),
        .size (host_size),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    ata_lane_swap #(
        .DATA_W (DATA_W)
    ) u_wr_swap (
        .din  (host_wdata),
        .size (host_size),
        .dout (dev_wdata)
    );

    ata_lane_swap #(
        .DATA_W (DATA_W)
    ) u_rd_swap (
        .din  (dev_rdata),
        .size (size_q),
        .dout (rd_swapped)
    );

    always_comb begin
        miss_data = '1;
        unique case (acc_size_e'(host_size))
            SZ_BYTE: miss_data = DATA_W'(8'hFF);
            SZ_HALF: miss_data = DATA_W'({HALF_W{1'b1}});
            SZ_WORD, SZ_RSVD: miss_data = '1;
        endcase
    end

    assign issue_rd = host_req && !host_we && dec_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue_rd) state_d = ST_WAIT;   // issue
            ST_WAIT: state_d = ST_IDLE;                 // complete
        endcase
    end

    // State register and read context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= 2'd0;
            sel_q   <= SEL_DATA;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && issue_rd) begin
                size_q <= host_size;
                sel_q  <= dec_sel;
            end
        end
    end

    // Outputs
    always_comb begin
        host_ack   = 1'b0;
        host_rdata = miss_data;
        dev_rd     = 1'b0;
        dev_wr     = 1'b0;
        dev_sel    = dec_sel;
        dev_size   = host_size;
        unique case (state_q)
            ST_IDLE: begin
                dev_rd   = issue_rd;
                dev_wr   = host_req && host_we && dec_hit;
                host_ack = host_req && (host_we || !dec_hit);
            end
            ST_WAIT: begin
                host_ack   = 1'b1;
                host_rdata = rd_swapped;
                dev_sel    = sel_q;
                dev_size   = size_q;
            end
        endcase
    end

    AST_RD_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |=> host_ack);                                              // R7
    AST_RD_NO_SAME_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> !host_ack);                                             // R7
    AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |=> !dev_rd);                                               // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rd, dev_wr}));                                       // R8
    AST_WR_ACK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && state_q == ST_IDLE) |-> host_ack);         // R8
    AST_WIDE_DATAPORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && dev_size != 2'd0) |-> dev_sel == SEL_DATA); // R5
    AST_BYTE_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && dev_size == 2'd0)
            |-> (dev_sel >= 4'd1 && dev_sel <= SEL_CTRL));                 // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_req && state_q == ST_IDLE) |-> !(host_ack || dev_rd || dev_wr)); // R9
endmodule

// File: tb/test_ata_mmio_bridge.sv
`timescale 1ns/1ps
module test_ata_mmio_bridge;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [1:0]        host_size = 2'd0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              host_ack;
    logic [DATA_W-1:0] host_rdata;
    logic [3:0]        dev_sel;
    logic [1:0]        dev_size;
    logic              dev_rd;
    logic              dev_wr;
    logic [DATA_W-1:0] dev_wdata;
    logic [DATA_W-1:0] dev_rdata = '0;

    int applied = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    ata_mmio_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ata_mmio_bridge (
        .clk, .rst_n, .host_req, .host_we, .host_size, .host_addr, .host_wdata,
        .host_ack, .host_rdata, .dev_sel, .dev_size, .dev_rd, .dev_wr,
        .dev_wdata, .dev_rdata
    );

    // Drive model: data one cycle after the read strobe
    always @(posedge clk) if (dev_rd) dev_rdata <= 32'hA1B2C3D0 + 32'(dev_sel);

    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [1:0]  kind;   // 0 none, 1 read strobe, 2 write strobe
        logic [3:0]  sel;
        logic [31:0] val;    // dev_wdata for writes, host_rdata for reads
        logic        waits;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 16'h0010, 32'hAABBCC5A, 2'd2, 4'd1, 32'h0000005A, 1'b0, 4'd2}, // R2
        '{1'b1, 2'd0, 16'h0160, 32'h00000006, 2'd2, 4'd8, 32'h00000006, 1'b0, 4'd3}, // R3
        '{1'b1, 2'd0, 16'h0080, 32'h0000000C, 2'd2, 4'd8, 32'h0000000C, 1'b0, 4'd3}, // R3
        '{1'b1, 2'd0, 16'h0090, 32'h00000011, 2'd0, 4'd0, 32'h0,        1'b0, 4'd4}, // R4
        '{1'b1, 2'd1, 16'h0000, 32'h0000BEEF, 2'd2, 4'd0, 32'h0000EFBE, 1'b0, 4'd6}, // R6
        '{1'b1, 2'd2, 16'h0004, 32'h01020304, 2'd2, 4'd0, 32'h04030201, 1'b0, 4'd6}, // R6
        '{1'b1, 2'd2, 16'h0020, 32'h55555555, 2'd0, 4'd0, 32'h0,        1'b0, 4'd5}, // R5
        '{1'b1, 2'd3, 16'h0000, 32'h12345678, 2'd0, 4'd0, 32'h0,        1'b0, 4'd5}, // R5
        '{1'b0, 2'd0, 16'h0070, 32'h0,        2'd1, 4'd7, 32'h000000D7, 1'b1, 4'd3}, // R3
        '{1'b0, 2'd0, 16'h0160, 32'h0,        2'd1, 4'd8, 32'h000000D8, 1'b1, 4'd3}, // R3
        '{1'b0, 2'd0, 16'h00F0, 32'h0,        2'd0, 4'd0, 32'h000000FF, 1'b0, 4'd4}, // R4
        '{1'b0, 2'd0, 16'h0000, 32'h0,        2'd0, 4'd0, 32'h000000FF, 1'b0, 4'd4}, // R4
        '{1'b0, 2'd1, 16'h0000, 32'h0,        2'd1, 4'd0, 32'h0000D0C3, 1'b1, 4'd6}, // R6
        '{1'b0, 2'd2, 16'h0008, 32'h0,        2'd1, 4'd0, 32'hD0C3B2A1, 1'b1, 4'd6}, // R6
        '{1'b0, 2'd1, 16'h0030, 32'h0,        2'd0, 4'd0, 32'h0000FFFF, 1'b0, 4'd5}, // R5
        '{1'b0, 2'd2, 16'h0FF0, 32'h0,        2'd0, 4'd0, 32'hFFFFFFFF, 1'b0, 4'd5}, // R5
        '{1'b0, 2'd0, 16'hA030, 32'h0,        2'd1, 4'd3, 32'h000000D3, 1'b1, 4'd1}, // R1
        '{1'b0, 2'd0, 16'h001F, 32'h0,        2'd1, 4'd1, 32'h000000D1, 1'b1, 4'd1}, // R1
        '{1'b0, 2'd3, 16'h0000, 32'h0,        2'd0, 4'd0, 32'hFFFFFFFF, 1'b0, 4'd5}, // R5
        '{1'b1, 2'd0, 16'hF050, 32'h000000A5, 2'd2, 4'd5, 32'h000000A5, 1'b0, 4'd1}  // R1
    };

    logic [1:0]  got_kind;
    logic [3:0]  got_sel;
    logic [31:0] got_wdata;
    logic [31:0] got_rdata;
    int          got_wait;
    logic        late_rd;

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_access(input logic we, input logic [1:0] size,
                              input logic [15:0] addr, input logic [31:0] wdata);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_size = size;
        host_addr = addr; host_wdata = wdata;
        #1;
        got_kind  = dev_wr ? 2'd2 : (dev_rd ? 2'd1 : 2'd0);
        got_sel   = dev_sel;
        got_wdata = dev_wdata;
        got_wait  = 0;
        late_rd   = 1'b0;
        while (!host_ack && got_wait < 4) begin
            @(negedge clk); #1;
            got_wait++;
            if (dev_rd) late_rd = 1'b1;
        end
        got_rdata = host_rdata;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        // R9: reset state, request low
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R9", "ack in reset", 32'(host_ack), 32'd0);
        check("R9", "strobes in reset", 32'({dev_rd, dev_wr}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9", "ack idle", 32'(host_ack), 32'd0);
        check("R9", "strobes idle", 32'({dev_rd, dev_wr}), 32'd0);

        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].rq);
            run_access(VECS[v].we, VECS[v].size, VECS[v].addr, VECS[v].wdata);
            check(rq, $sformatf("vec %0d strobe kind", v), 32'(got_kind), 32'(VECS[v].kind));
            if (VECS[v].kind != 2'd0)
                check(rq, $sformatf("vec %0d dev_sel", v), 32'(got_sel), 32'(VECS[v].sel));
            if (VECS[v].we && VECS[v].kind == 2'd2)
                check(rq, $sformatf("vec %0d dev_wdata", v), got_wdata, VECS[v].val);
            if (!VECS[v].we)
                check(rq, $sformatf("vec %0d host_rdata", v), got_rdata, VECS[v].val);
            if (VECS[v].waits)
                check("R7", $sformatf("vec %0d wait states", v), 32'(got_wait), 32'd1);
            else
                check("R8", $sformatf("vec %0d wait states", v), 32'(got_wait), 32'd0);
        end

        // R7: read strobe lasts only the request cycle
        run_access(1'b0, 2'd0, 16'h0070, 32'h0);
        check("R7", "dev_rd in wait state", 32'(late_rd), 32'd0);

        // R3: alternate-status alias never issues a status-register read
        run_access(1'b0, 2'd0, 16'h0080, 32'h0);
        check("R3", "alt status sel", 32'(got_sel), 32'd8);

        // R9: after the handshake, nothing asserted with request low
        @(negedge clk); #1;
        check("R9", "ack after release", 32'(host_ack), 32'd0);
        check("R9", "strobes after release", 32'({dev_rd, dev_wr}), 32'd0);

        // R8: back-to-back writes each acked in their own cycle
        run_access(1'b1, 2'd0, 16'h0020, 32'h000000E2);
        check("R8", "b2b write 1 wait", 32'(got_wait), 32'd0);
        check("R2", "b2b write 1 sel", 32'(got_sel), 32'd2);
        run_access(1'b1, 2'd0, 16'h0060, 32'h000000E6);
        check("R8", "b2b write 2 wait", 32'(got_wait), 32'd0);
        check("R2", "b2b write 2 sel", 32'(got_sel), 32'd6);

        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule